// File: doc/BRIEF.md
# Bus-Master Drain and Guarded Soft Reset

This block is a single host-visible control and status word for a storage controller. It lets software bring the controller to a clean global reset. Software first sets a stop request, which tells the bus-master engine to start no new transactions. The block then watches the engine's count of outstanding transactions. Once that count is zero while the stop request is held, it reports the master as drained.

A global soft reset can be armed only after the drain has been reported. While the soft-reset bit stays set, the block holds the controller's internal reset asserted. The internal reset does not touch this word, so only software writes change the stop and soft-reset bits.

Every write replaces the writable bits from the written word, and a read returns the current state. The drained indication stays set until the master takes on a new transaction.

Top module: `bmrst_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0, and both `bm_stop` and `core_rst` are 0.
- R2: A write copies `wr_data` bit 2 into the stop bit. That bit reads back at `rd_data` bit 2 from the cycle after the write, and `bm_stop` follows it.
- R3: When the stop bit is 1 and `bm_busy_cnt` is 0 at a clock edge, the drained flag (`rd_data` bit 3) reads 1 after that edge. While `bm_busy_cnt` is nonzero, the flag reads 0 from the following edge on.
- R4: The drained flag is read-only: a write to bit 3 has no effect on it.
- R5: A write with bit 4 set while the drained flag reads 1 sets the soft-reset bit, so `rd_data` bit 4 reads 1. `core_rst` is then 1 for every cycle that bit stays 1.
- R6: A write with bit 4 set while the drained flag reads 0 and the soft-reset bit is 0 is ignored. Bit 4 and `core_rst` stay 0.
- R7: A write with bit 4 clear clears the soft-reset bit, and `core_rst` drops after the same edge.
- R8: While `core_rst` is asserted, the stop and soft-reset bits change only through writes.
- R9: After the stop bit is cleared, the drained flag stays 1 while `bm_busy_cnt` is 0. It drops after the first edge at which the count is nonzero.
- R10: `rd_data` bits other than 2, 3 and 4 always read 0, even after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register contents |
| bm_busy_cnt | input | CNT_W | Outstanding bus-master transactions |
| bm_stop | output | 1 | Request to the bus master to start no new transactions |
| core_rst | output | 1 | Internal soft reset to the controller, active high |

## Verification
The hardest state to reach is a write that sets the soft-reset bit while the drained flag is 0 but the stop bit is already 1. A single write cannot put both the stop request and an outstanding count in place, so the bench first sets stop while holding the busy count nonzero. It then issues the reset request before letting the count fall. A long, deterministic mixed sweep interleaves writes of every bit pattern with busy counts that rise and fall. This covers the sticky drained flag and the release of the stop bit around an armed reset. Every cycle is compared against an arithmetic model of the three bits.

// File: rtl/bmrst_pkg.sv
package bmrst_pkg;
    localparam int STOP_POS  = 2;
    localparam int EMPTY_POS = 3;
    localparam int SRST_POS  = 4;

    typedef struct packed {
        logic stop;
    } top_state_t;
endpackage

// File: rtl/bmrst_drain_track.sv
module bmrst_drain_track #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] busy_cnt,
    output logic             drained
);
    logic idle;
    logic drained_d, drained_q;

    assign idle = (busy_cnt == '0);

    always_comb begin
        drained_d = drained_q;
        if (!idle)
            drained_d = 1'b0;
        else if (stop_req)
            drained_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drained_q <= 1'b0;
        else        drained_q <= drained_d;
    end

    assign drained = drained_q;

    // R3: a held stop with nothing outstanding reports drained
    assert_drain_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && idle) |=> drained);
    // R9: the flag holds while idle and falls only after a new transaction
    assert_drain_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drained && idle) |=> drained);
    assert_drain_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drained) |-> ($past(busy_cnt) != '0));
endmodule

// File: rtl/bmrst_srst_gate.sv
module bmrst_srst_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic req_bit,
    input  logic drained,
    output logic srst
);
    logic srst_d, srst_q;

    always_comb begin
        srst_d = srst_q;
        if (wr_en)
            srst_d = req_bit ? (srst_q | drained) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= srst_d;
    end

    assign srst = srst_q;

    // R6: a request before the drain is reported is dropped
    assert_early_req_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_bit && !drained && !srst) |=> !srst);
    // R7: writing zero releases the reset
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !req_bit) |=> !srst);
    // R8: without a write the bit cannot move
    assert_srst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(srst));
    // R5: a rising reset always follows a reported drain
    assert_rise_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst) |-> $past(drained));
endmodule

// File: rtl/bmrst_ctrl.sv
module bmrst_ctrl #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  bm_busy_cnt,
    output logic              bm_stop,
    output logic              core_rst
);
    import bmrst_pkg::*;

    top_state_t st_d, st_q;
    logic drained;
    logic srst;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.stop = wr_data[STOP_POS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bmrst_drain_track #(.CNT_W(CNT_W)) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (st_q.stop),
        .busy_cnt (bm_busy_cnt),
        .drained  (drained)
    );

    bmrst_srst_gate u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .req_bit (wr_data[SRST_POS]),
        .drained (drained),
        .srst    (srst)
    );

    always_comb begin
        rd_data            = '0;
        rd_data[STOP_POS]  = st_q.stop;
        rd_data[EMPTY_POS] = drained;
        rd_data[SRST_POS]  = srst;
    end

    assign bm_stop  = st_q.stop;
    assign core_rst = srst;

    // R2: the stop bit takes the written value
    assert_stop_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bm_stop == $past(wr_data[STOP_POS])));
    // R8: the stop bit holds without a write, also under soft reset
    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bm_stop));
endmodule

// File: tb/sim_bmrst_ctrl.sv
`timescale 1ns/1ps
module sim_bmrst_ctrl;
    localparam int DW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] busy = '0;
    logic [DW-1:0] rd_data;
    logic          bm_stop, core_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic m_stop = 0, m_empty = 0, m_srst = 0;

    always #4 clk = ~clk;

    bmrst_ctrl #(.DATA_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bm_busy_cnt(busy), .bm_stop(bm_stop), .core_rst(core_rst)
    );

    function automatic logic [DW-1:0] exp_word();
        logic [DW-1:0] w = '0;
        w[2] = m_stop; w[3] = m_empty; w[4] = m_srst;
        return w;
    endfunction

    task automatic check(input string req);
        checks++;
        if (rd_data !== exp_word() || bm_stop !== m_stop || core_rst !== m_srst) begin
            errors++;
            $display("FAIL %s: rd=%h stop=%b rst=%b expected rd=%h stop=%b rst=%b",
                     req, rd_data, bm_stop, core_rst, exp_word(), m_stop, m_srst);
        end
    endtask

    // one clock: drive at negedge, update the model at the edge, sample after it
    task automatic step(input logic we, input logic [DW-1:0] wd,
                        input logic [CW-1:0] cnt, input string req);
        logic n_stop, n_empty, n_srst;
        @(negedge clk);
        wr_en = we; wr_data = wd; busy = cnt;
        @(posedge clk);
        n_stop  = we ? wd[2] : m_stop;
        n_empty = (cnt != 0) ? 1'b0 : (m_stop ? 1'b1 : m_empty);
        n_srst  = we ? (wd[4] ? (m_srst | m_empty) : 1'b0) : m_srst;
        m_stop = n_stop; m_empty = n_empty; m_srst = n_srst;
        #1;
        check(req);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1");
        @(negedge clk) rst_n = 1'b1;
        step(0, '0, 0, "R1");

        // R6: reset request before any stop
        step(1, 32'h10, 0, "R6");
        // R2 stop set while busy; R6 request with stop but not drained
        step(1, 32'h04, 3, "R2");
        step(0, '0, 3, "R3");
        step(1, 32'h14, 3, "R6");
        step(0, '0, 3, "R6");
        // R3 drain completes
        step(0, '0, 0, "R3");
        step(0, '0, 0, "R3");
        // R4 writing bit 3 alone does not set or clear the flag
        step(1, 32'h0C, 0, "R4");
        step(1, 32'h04, 0, "R4");
        // R5 arm reset, R8 hold many cycles
        step(1, 32'h14, 0, "R5");
        for (int k = 0; k < 20; k++) step(0, '0, 0, "R8");
        // R10 all ones keeps unused bits at zero
        step(1, '1, 0, "R10");
        // R7 release
        step(1, 32'h04, 0, "R7");
        // R9 stop cleared, flag holds until new work
        step(1, 32'h00, 0, "R9");
        for (int k = 0; k < 5; k++) step(0, '0, 0, "R9");
        step(0, '0, 1, "R9");
        step(0, '0, 0, "R9");

        // sweep: every pattern of bits 0..4 from both drained and busy states
        for (int pre = 0; pre < 2; pre++) begin
            for (int p = 0; p < 32; p++) begin
                step(1, 32'h04, pre ? 0 : 2, "R2");
                step(0, '0, pre ? 0 : 2, "R3");
                step(1, DW'(p), pre ? 0 : 2, "R5");
                step(0, '0, 0, "R8");
                step(1, 32'h00, 1, "R7");
            end
        end

        // mixed deterministic sweep
        for (int i = 0; i < 600; i++) begin
            logic [CW-1:0] c;
            c = ((i % 7) < 3) ? '0 : CW'((i * 5) % 16);
            step((i % 3) == 0, DW'((i * 37) ^ (i << 3)), c, "R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule